// File: doc/BRIEF.md
# Write Status Bit Generator

This block forms the word a host sees when it reads the flash array while an internal program or erase is running, or while an erase is suspended. It sits on the read data path, takes the array word as its default value, and replaces up to three bit lanes with status information. Bit 7 gives an inverted-data polling flag. Bit 6 gives a toggle flag that changes on every read. Bit 2 gives a second toggle that marks reads that land inside the region whose erase has been suspended.

The command decoder supplies a busy flag, the type of operation, a suspended flag and a region-match signal. The array read path supplies the raw word and a one-cycle read strobe. The output is combinational from these inputs and a few state bits. A read shows the toggle state held before its strobe. The toggle advances at the clock edge that ends the strobe cycle.

Top module: `wstat_gen`

## Requirements
- R1: When busy is low and the read is not a suspended-region read, the output equals the array word in every bit.
- R2: During a program (busy high, operation flag low at the first busy cycle), bit 7 reads as the complement of the programmed bit 7 sampled on the first busy cycle. Later changes to that input have no effect until busy drops.
- R3: During an erase (operation flag high at the first busy cycle), bit 7 reads as 0. Later changes to the operation flag have no effect until busy drops.
- R4: While busy, the first read gives bit 6 = 0. Each strobe that is not a suspended-region read inverts bit 6 for the next read. Bit 6 holds when no strobe occurs, and the toggle returns to 0 whenever busy is low.
- R5: While busy, every bit except bits 7 and 6 comes from the array word.
- R6: A suspended-region read (suspended high and region match high) returns bit 6 = 1 and bit 2 from the suspend toggle. All other bits come from the array word.
- R7: The suspend toggle starts at 0 and inverts only on strobes of suspended-region reads. It returns to 0 whenever the suspended flag is low.
- R8: A suspended-region read takes priority over busy polling, and it does not advance the bit 6 toggle.
- R9: Reset clears both toggles and the captured operation state, so the first status read after reset gives bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | 1 = erase, 0 = program, sampled on the first busy cycle |
| susp_i | input | 1 | An erase is suspended |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_in_susp_i | input | 1 | Read address lies in the suspended region |
| prog_b7_i | input | 1 | Bit 7 of the word being programmed |
| arr_data_i | input | DW | Raw array read word |
| rd_data_o | output | DW | Read word with the status bits applied |

## Verification
On every cycle the assertions check the following: pass-through when idle, the polling value of bit 7 on the first busy cycle for both operation types, the flip or hold of bit 6 from one busy cycle to the next, bit 6 held high and bit 2 flipping on suspended-region reads, and a first busy read giving bit 6 = 0. Only the bench's scenarios can show a few other behaviours: that the sampled programmed bit and operation type are held for the whole operation, that the suspend toggle restarts at 0 after a resume, and that suspended-region reads made during a program leave the bit 6 sequence unbroken. These depend on history longer than one cycle.

// File: rtl/wstat_gen.sv
module wstat_gen #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6,
  parameter int SUS_BIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic          susp_i,
  input  logic          rd_stb_i,
  input  logic          rd_in_susp_i,
  input  logic          prog_b7_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);

  logic busy_q, cap_b7, cap_erase, tog6, tog2;

  wire sus_hit  = susp_i & rd_in_susp_i;
  wire eff_b7   = busy_q ? cap_b7 : prog_b7_i;
  wire eff_er   = busy_q ? cap_erase : op_erase_i;
  wire poll_bit = eff_er ? 1'b0 : ~eff_b7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cap_b7    <= 1'b0;
      cap_erase <= 1'b0;
      tog6      <= 1'b0;
      tog2      <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (!busy_q) begin
        cap_b7    <= prog_b7_i;
        cap_erase <= op_erase_i;
      end
      if (!busy_i)                     tog6 <= 1'b0;
      else if (rd_stb_i && !sus_hit)   tog6 <= ~tog6;
      if (!susp_i)                     tog2 <= 1'b0;
      else if (rd_stb_i && sus_hit)    tog2 <= ~tog2;
    end
  end

  always_comb begin
    rd_data_o = arr_data_i;
    if (sus_hit) begin
      rd_data_o[TOG_BIT] = 1'b1;
      rd_data_o[SUS_BIT] = tog2;
    end else if (busy_i) begin
      rd_data_o[POLL_BIT] = poll_bit;
      rd_data_o[TOG_BIT]  = tog6;
    end
  end

endmodule

// File: rtl/wstat_gen_chk.sv
module wstat_gen_chk #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6,
  parameter int SUS_BIT  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          op_erase_i,
  input logic          susp_i,
  input logic          rd_stb_i,
  input logic          rd_in_susp_i,
  input logic          prog_b7_i,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] rd_data_o
);

  wire hit = susp_i && rd_in_susp_i;

  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !hit) |-> (rd_data_o == arr_data_i));

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !$past(busy_i) && !op_erase_i && !hit) |-> (rd_data_o[POLL_BIT] == !prog_b7_i));

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !$past(busy_i) && op_erase_i && !hit) |-> (rd_data_o[POLL_BIT] == 1'b0));

  assert_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !$past(busy_i) && !hit) |-> (rd_data_o[TOG_BIT] == 1'b0));

  assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !hit && rd_stb_i) ##1 (busy_i && !hit) |-> (rd_data_o[TOG_BIT] != $past(rd_data_o[TOG_BIT])));

  assert_tog_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !hit && !rd_stb_i) ##1 (busy_i && !hit) |-> $stable(rd_data_o[TOG_BIT]));

  assert_sus_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rd_data_o[TOG_BIT] == 1'b1));

  assert_sus_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_stb_i) ##1 hit |-> (rd_data_o[SUS_BIT] != $past(rd_data_o[SUS_BIT])));

endmodule

bind wstat_gen wstat_gen_chk #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .SUS_BIT(SUS_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_erase_i(op_erase_i), .susp_i(susp_i),
  .rd_stb_i(rd_stb_i), .rd_in_susp_i(rd_in_susp_i), .prog_b7_i(prog_b7_i),
  .arr_data_i(arr_data_i), .rd_data_o(rd_data_o)
);

// File: tb/wstat_gen_tb.sv
module wstat_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busy, er, susp, stb, insus, b7;
  logic [15:0] arr, rdo;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wstat_gen u_dut (.clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(er), .susp_i(susp),
    .rd_stb_i(stb), .rd_in_susp_i(insus), .prog_b7_i(b7), .arr_data_i(arr), .rd_data_o(rdo));

  // {busy, erase, susp, in_susp, stb, b7, arr, expected}
  localparam logic [37:0] VEC [20] = '{
    {6'b000000, 16'hA5A5, 16'hA5A5},  // R1 idle
    {6'b100011, 16'h00FF, 16'h003F},  // R2 R4 R5 first program read
    {6'b100010, 16'h00FF, 16'h007F},  // R2 b7 change ignored, R4 flip
    {6'b100000, 16'h0000, 16'h0000},  // R4 no flip without strobe
    {6'b100010, 16'h0000, 16'h0000},  // R4 hold
    {6'b000000, 16'h1280, 16'h1280},  // R1 complete
    {6'b110011, 16'hFFFF, 16'hFF3F},  // R3 R5 erase
    {6'b100011, 16'hFFFF, 16'hFF7F},  // R3 op change ignored
    {6'b001110, 16'h0000, 16'h0040},  // R6
    {6'b001110, 16'h0000, 16'h0044},  // R7 flip
    {6'b001010, 16'h1234, 16'h1234},  // R1 R7 outside region
    {6'b001100, 16'hFFFB, 16'hFFFB},  // R6 R7 no advance
    {6'b001110, 16'hFFBF, 16'hFFFB},  // R6 bit6 forced
    {6'b001100, 16'h0000, 16'h0044},  // R7
    {6'b000000, 16'h0040, 16'h0040},  // R1 resume
    {6'b001100, 16'h0000, 16'h0040},  // R7 restart at 0
    {6'b101010, 16'h0000, 16'h0080},  // R2 program in suspend
    {6'b101110, 16'h0000, 16'h0040},  // R8 signature wins
    {6'b101010, 16'h0000, 16'h00C0},  // R8 bit6 sequence intact
    {6'b000000, 16'h5555, 16'h5555}   // R1
  };

  task automatic chk(input string req, input logic [15:0] exp);
    total++;
    if (rdo !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, rdo, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [15:0] a);
    {busy, er, susp, insus, stb, b7} = c;
    arr = a;
  endtask

  initial begin
    drive(6'b000000, 16'h1111);
    repeat (3) @(negedge clk);
    #1 chk("R9 reset pass", 16'h1111);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      drive(VEC[i][37:32], VEC[i][31:16]);
      #1 chk($sformatf("vec%0d R1-R8", i), VEC[i][15:0]);
      @(negedge clk);
    end
    // R9: reset in the middle of a program
    drive(6'b100010, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    drive(6'b000000, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    drive(6'b100010, 16'h0000);
    #1 chk("R9 first read after reset", 16'h0080);
    @(negedge clk);
    #1 chk("R4 second read after reset", 16'h00C0);
    @(negedge clk);
    drive(6'b000000, 16'h0000);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule